// File: doc/BRIEF.md
# NIC Register Access Decoder

This block is the programmed-I/O front end of a packet network interface. A host issues one register access at a time over a small request/response bus. The block takes the low 12 bits of the address as the register offset. It checks that the offset is mapped, that the register allows the requested direction, and that the access size matches the register width. It then answers with read data, or with an error bit and zero data.

The receive-done and transmit-done status words are assembled live from sideband inputs: FIFO packet counts, transmit free space, transmit fill level and engine idle flags. The wait copies of those words hold their read until the matching engine is idle. Writes update the configuration word and the interrupt mask. They clear interrupt status bits, issue a soft reset, or hand a 64-bit descriptor to the receive or transmit DMA engine through a one-cycle strobe. The interrupt block posts status bits through a sideband input.

Top module: `nic_reg_front`

## Requirements
- R1: Only the low 12 bits of `req_addr` select the register, so an address differing only above bit 11 reaches the same register.
- R2: Each of the following makes the response carry `resp_error`=1 and `resp_rdata`=0 with no state change: an unmapped offset, a read of a write-only register (command 0x004, rx descriptor 0x028, tx descriptor 0x040), a write to a read-only register (0x010 to 0x024, 0x030, 0x038, 0x048, 0x050, 0x058), and a `req_size` other than the register's width (4 bytes for 0x000 to 0x024, 8 bytes for the others).
- R3: An accepted request gets exactly one response. It appears in the cycle after acceptance unless the read is held. `req_ready` stays low while a response is outstanding or held. A response whose `resp_ready` is low keeps its data and error bit.
- R4: The rx done word (0x030), and its wait copy (0x038), carry the rx packet count in bits [CNTW-1:0], saturated at 2^CNTW-1 when SAT_COUNT=1. Bit 32 is set while the rx engine is not idle.
- R5: The tx done word (0x048), and its wait copy (0x050), carry the tx packet count in bits [CNTW-1:0] and busy in bit 32. Bit 33 (full) is set when `tx_free` < TX_MAXCOPY. Bit 34 (low) is set when `tx_level` < TX_MARK.
- R6: A read of interrupt status (0x008) returns the value before the access and clears it. Bits posted in the same cycle survive.
- R7: A write to interrupt status clears only the bits set in both the written value and the status. Bits on `intr_post` are ORed into the status.
- R8: A write to the command register (0x004) with bit 0 set clears the configuration word and the status, restores the mask to IMASK_RST, and pulses `dev_reset` for one cycle. With bit 0 clear, the write changes nothing.
- R9: A read of a wait word while its engine is busy produces no response. The response arrives in the cycle after the idle flag is seen, and carries the word as it is at that moment.
- R10: A descriptor write to an idle engine pulses `rx_desc_stb` or `tx_desc_stb` for one cycle, with the 64-bit value on `rx_desc` or `tx_desc`. A descriptor write to a busy engine is an error and raises no strobe.
- R11: After reset: configuration 0 (0x000), status 0, mask IMASK_RST (0x00C). Reads of 0x010 to 0x024 return RX_MAXCOPY, TX_MAXCOPY, RX_MARK, TX_MARK, RX_FSZ and TX_FSZ in that order. 0x058 returns STATION.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response present |
| resp_error | output | 1 | Access rejected |
| resp_rdata | output | 64 | Read data, zero-extended |
| resp_ready | input | 1 | Response taken |
| rx_pkts | input | PKTW | Rx FIFO packet count |
| tx_pkts | input | PKTW | Tx FIFO packet count |
| tx_free | input | LW | Tx FIFO free bytes |
| tx_level | input | LW | Tx FIFO occupied bytes |
| rx_idle | input | 1 | Rx engine idle |
| tx_idle | input | 1 | Tx engine idle |
| intr_post | input | IW | Interrupt bits to set |
| cfg_word | output | 32 | Configuration word |
| intr_mask | output | IW | Interrupt mask |
| intr_status | output | IW | Interrupt status |
| dev_reset | output | 1 | Soft reset pulse |
| rx_desc_stb | output | 1 | Rx descriptor strobe |
| rx_desc | output | 64 | Rx descriptor value |
| tx_desc_stb | output | 1 | Tx descriptor strobe |
| tx_desc | output | 64 | Tx descriptor value |

## Verification
The bench attacks a wait read against a busy engine. A design that answered early would return a stale busy word, and one that never re-checked the idle flag would hang until the watchdog fires. It also posts an interrupt in the very cycle the status is read: a design that let the clear win would lose that event. Packet counts above the field width, a full-versus-low flag pair, and address aliasing above bit 11 are each driven. Wrong-size and wrong-direction accesses and a descriptor write to a busy engine are checked for an error with zero data and no strobe.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;

   typedef enum logic [4:0] {
      RK_NONE, RK_CFG, RK_CMD, RK_ISTAT, RK_IMASK,
      RK_RXMC, RK_TXMC, RK_RXMK, RK_TXMK, RK_RXFS, RK_TXFS,
      RK_RXDESC, RK_RXDONE, RK_RXWAIT,
      RK_TXDESC, RK_TXDONE, RK_TXWAIT, RK_STN
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e kind;
      logic      can_rd;
      logic      can_wr;
      logic      wide;
   } reg_attr_t;

   localparam logic [11:0] OFF_CFG    = 12'h000;
   localparam logic [11:0] OFF_CMD    = 12'h004;
   localparam logic [11:0] OFF_ISTAT  = 12'h008;
   localparam logic [11:0] OFF_IMASK  = 12'h00C;
   localparam logic [11:0] OFF_RXMC   = 12'h010;
   localparam logic [11:0] OFF_TXMC   = 12'h014;
   localparam logic [11:0] OFF_RXMK   = 12'h018;
   localparam logic [11:0] OFF_TXMK   = 12'h01C;
   localparam logic [11:0] OFF_RXFS   = 12'h020;
   localparam logic [11:0] OFF_TXFS   = 12'h024;
   localparam logic [11:0] OFF_RXDESC = 12'h028;
   localparam logic [11:0] OFF_RXDONE = 12'h030;
   localparam logic [11:0] OFF_RXWAIT = 12'h038;
   localparam logic [11:0] OFF_TXDESC = 12'h040;
   localparam logic [11:0] OFF_TXDONE = 12'h048;
   localparam logic [11:0] OFF_TXWAIT = 12'h050;
   localparam logic [11:0] OFF_STN    = 12'h058;

   localparam int BUSY_BIT      = 32;
   localparam int FULL_BIT      = 33;
   localparam int LOW_BIT       = 34;
   localparam int CMD_RESET_BIT = 0;

   function automatic reg_attr_t reg_lookup(input logic [11:0] off);
      reg_attr_t a;
      a = '{kind: RK_NONE, can_rd: 1'b0, can_wr: 1'b0, wide: 1'b0};
      case (off)
         OFF_CFG:    a = '{RK_CFG,    1'b1, 1'b1, 1'b0};
         OFF_CMD:    a = '{RK_CMD,    1'b0, 1'b1, 1'b0};
         OFF_ISTAT:  a = '{RK_ISTAT,  1'b1, 1'b1, 1'b0};
         OFF_IMASK:  a = '{RK_IMASK,  1'b1, 1'b1, 1'b0};
         OFF_RXMC:   a = '{RK_RXMC,   1'b1, 1'b0, 1'b0};
         OFF_TXMC:   a = '{RK_TXMC,   1'b1, 1'b0, 1'b0};
         OFF_RXMK:   a = '{RK_RXMK,   1'b1, 1'b0, 1'b0};
         OFF_TXMK:   a = '{RK_TXMK,   1'b1, 1'b0, 1'b0};
         OFF_RXFS:   a = '{RK_RXFS,   1'b1, 1'b0, 1'b0};
         OFF_TXFS:   a = '{RK_TXFS,   1'b1, 1'b0, 1'b0};
         OFF_RXDESC: a = '{RK_RXDESC, 1'b0, 1'b1, 1'b1};
         OFF_RXDONE: a = '{RK_RXDONE, 1'b1, 1'b0, 1'b1};
         OFF_RXWAIT: a = '{RK_RXWAIT, 1'b1, 1'b0, 1'b1};
         OFF_TXDESC: a = '{RK_TXDESC, 1'b0, 1'b1, 1'b1};
         OFF_TXDONE: a = '{RK_TXDONE, 1'b1, 1'b0, 1'b1};
         OFF_TXWAIT: a = '{RK_TXWAIT, 1'b1, 1'b0, 1'b1};
         OFF_STN:    a = '{RK_STN,    1'b1, 1'b0, 1'b1};
         default: ;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/nic_reg_decode.sv
module nic_reg_decode
   import nic_reg_pkg::*;
(
   input  logic [11:0] off,
   input  logic        is_write,
   input  logic [3:0]  size,
   input  logic        rx_idle,
   input  logic        tx_idle,
   output reg_kind_e   kind,
   output logic        bad,
   output logic        hold,
   output logic        hold_tx
);
   reg_attr_t attr;
   logic      dir_bad, size_bad, busy_bad;

   assign attr     = reg_lookup(off);
   assign kind     = attr.kind;
   assign dir_bad  = is_write ? !attr.can_wr : !attr.can_rd;
   assign size_bad = size != (attr.wide ? 4'd8 : 4'd4);
   assign busy_bad = is_write &&
                     ((attr.kind == RK_RXDESC && !rx_idle) ||
                      (attr.kind == RK_TXDESC && !tx_idle));
   assign bad      = (attr.kind == RK_NONE) || dir_bad || size_bad || busy_bad;
   assign hold     = !bad && !is_write &&
                     ((attr.kind == RK_RXWAIT && !rx_idle) ||
                      (attr.kind == RK_TXWAIT && !tx_idle));
   assign hold_tx  = (attr.kind == RK_TXWAIT);
endmodule

// File: rtl/nic_reg_status.sv
module nic_reg_status
   import nic_reg_pkg::*;
#(
   parameter int          PKTW       = 16,
   parameter int          CNTW       = 8,
   parameter int          LW         = 20,
   parameter bit          SAT_COUNT  = 1'b1,
   parameter int unsigned TX_MAXCOPY = 16384,
   parameter int unsigned TX_MARK    = 16384
) (
   input  logic [PKTW-1:0] rx_pkts,
   input  logic [PKTW-1:0] tx_pkts,
   input  logic [LW-1:0]   tx_free,
   input  logic [LW-1:0]   tx_level,
   input  logic            rx_idle,
   input  logic            tx_idle,
   output logic [63:0]     rx_word,
   output logic [63:0]     tx_word
);
   localparam int NCH = 2;

   logic [PKTW-1:0] pk  [NCH];
   logic [CNTW-1:0] cnt [NCH];

   assign pk[0] = rx_pkts;
   assign pk[1] = tx_pkts;

   for (genvar c = 0; c < NCH; c++) begin : g_cnt
      if (PKTW > CNTW) begin : g_narrow
         if (SAT_COUNT) begin : g_sat
            assign cnt[c] = (|pk[c][PKTW-1:CNTW]) ? '1 : pk[c][CNTW-1:0];
         end else begin : g_trunc
            assign cnt[c] = pk[c][CNTW-1:0];
         end
      end else begin : g_wide
         assign cnt[c] = CNTW'(pk[c]);
      end
   end

   always_comb begin
      rx_word                = '0;
      rx_word[CNTW-1:0]      = cnt[0];
      rx_word[BUSY_BIT]      = !rx_idle;
      tx_word                = '0;
      tx_word[CNTW-1:0]      = cnt[1];
      tx_word[BUSY_BIT]      = !tx_idle;
      tx_word[FULL_BIT]      = tx_free < LW'(TX_MAXCOPY);
      tx_word[LOW_BIT]       = tx_level < LW'(TX_MARK);
   end
endmodule

// File: rtl/nic_reg_front.sv
module nic_reg_front
   import nic_reg_pkg::*;
#(
   parameter int          AW         = 16,
   parameter int          IW         = 32,
   parameter int          PKTW       = 16,
   parameter int          CNTW       = 8,
   parameter int          LW         = 20,
   parameter bit          SAT_COUNT  = 1'b1,
   parameter int unsigned RX_MAXCOPY = 16384,
   parameter int unsigned TX_MAXCOPY = 16384,
   parameter int unsigned RX_MARK    = 49152,
   parameter int unsigned TX_MARK    = 16384,
   parameter int unsigned RX_FSZ     = 65536,
   parameter int unsigned TX_FSZ     = 65536,
   parameter logic [47:0] STATION    = 48'h0200_1122_3344,
   parameter logic [31:0] IMASK_RST  = 32'h0000_0015
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [3:0]      req_size,
   input  logic [63:0]     req_wdata,
   output logic            resp_valid,
   output logic            resp_error,
   output logic [63:0]     resp_rdata,
   input  logic            resp_ready,
   input  logic [PKTW-1:0] rx_pkts,
   input  logic [PKTW-1:0] tx_pkts,
   input  logic [LW-1:0]   tx_free,
   input  logic [LW-1:0]   tx_level,
   input  logic            rx_idle,
   input  logic            tx_idle,
   input  logic [IW-1:0]   intr_post,
   output logic [31:0]     cfg_word,
   output logic [IW-1:0]   intr_mask,
   output logic [IW-1:0]   intr_status,
   output logic            dev_reset,
   output logic            rx_desc_stb,
   output logic [63:0]     rx_desc,
   output logic            tx_desc_stb,
   output logic [63:0]     tx_desc
);
   localparam int OFFW = 12;

   if (AW < OFFW) begin : g_chk_aw
      $error("nic_reg_front: AW must be at least 12");
   end
   if (IW < 1 || IW > 32) begin : g_chk_iw
      $error("nic_reg_front: IW must be 1..32");
   end
   if (CNTW < 1 || CNTW > 32) begin : g_chk_cntw
      $error("nic_reg_front: CNTW must be 1..32");
   end
   if (LW > 32 || (64'(TX_MAXCOPY) >> LW) != 0 || (64'(TX_MARK) >> LW) != 0) begin : g_chk_lw
      $error("nic_reg_front: LW too narrow for transmit limits");
   end

   reg_kind_e   kind;
   logic        bad, hold, hold_tx;
   logic [63:0] rx_word, tx_word, rd_mux;
   logic        accept, rd_go, wr_go, soft_rst;
   logic [IW-1:0] clr, istat_d;

   logic [31:0]   cfg_q;
   logic [IW-1:0] imask_q, istat_q;
   logic          rv_q, re_q, pend_q, pend_tx_q;
   logic [63:0]   rd_q;

   logic unused_addr;
   assign unused_addr = ^req_addr[AW-1:OFFW];

   nic_reg_decode u_dec (
      .off      (req_addr[OFFW-1:0]),
      .is_write (req_write),
      .size     (req_size),
      .rx_idle  (rx_idle),
      .tx_idle  (tx_idle),
      .kind     (kind),
      .bad      (bad),
      .hold     (hold),
      .hold_tx  (hold_tx)
   );

   nic_reg_status #(
      .PKTW(PKTW), .CNTW(CNTW), .LW(LW), .SAT_COUNT(SAT_COUNT),
      .TX_MAXCOPY(TX_MAXCOPY), .TX_MARK(TX_MARK)
   ) u_stat (
      .rx_pkts(rx_pkts), .tx_pkts(tx_pkts),
      .tx_free(tx_free), .tx_level(tx_level),
      .rx_idle(rx_idle), .tx_idle(tx_idle),
      .rx_word(rx_word), .tx_word(tx_word)
   );

   assign req_ready = !rv_q && !pend_q;
   assign accept    = req_valid && req_ready;
   assign rd_go     = accept && !bad && !req_write && !hold;
   assign wr_go     = accept && !bad && req_write;
   assign soft_rst  = wr_go && kind == RK_CMD && req_wdata[CMD_RESET_BIT];

   always_comb begin
      case (kind)
         RK_CFG:    rd_mux = 64'(cfg_q);
         RK_ISTAT:  rd_mux = 64'(istat_q);
         RK_IMASK:  rd_mux = 64'(imask_q);
         RK_RXMC:   rd_mux = 64'(RX_MAXCOPY);
         RK_TXMC:   rd_mux = 64'(TX_MAXCOPY);
         RK_RXMK:   rd_mux = 64'(RX_MARK);
         RK_TXMK:   rd_mux = 64'(TX_MARK);
         RK_RXFS:   rd_mux = 64'(RX_FSZ);
         RK_TXFS:   rd_mux = 64'(TX_FSZ);
         RK_RXDONE, RK_RXWAIT: rd_mux = rx_word;
         RK_TXDONE, RK_TXWAIT: rd_mux = tx_word;
         RK_STN:    rd_mux = 64'(STATION);
         default:   rd_mux = '0;
      endcase
   end

   always_comb begin
      clr = '0;
      if (rd_go && kind == RK_ISTAT) clr = '1;
      if (wr_go && kind == RK_ISTAT) clr = req_wdata[IW-1:0] & istat_q;
      istat_d = soft_rst ? '0 : ((istat_q & ~clr) | intr_post);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         imask_q <= IMASK_RST[IW-1:0];
         istat_q <= '0;
      end else begin
         istat_q <= istat_d;
         if (soft_rst) begin
            cfg_q   <= '0;
            imask_q <= IMASK_RST[IW-1:0];
         end else if (wr_go) begin
            if (kind == RK_CFG)   cfg_q   <= req_wdata[31:0];
            if (kind == RK_IMASK) imask_q <= req_wdata[IW-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q <= 1'b0; re_q <= 1'b0; rd_q <= '0;
         pend_q <= 1'b0; pend_tx_q <= 1'b0;
      end else begin
         if (rv_q && resp_ready) rv_q <= 1'b0;
         if (accept) begin
            if (bad) begin
               rv_q <= 1'b1; re_q <= 1'b1; rd_q <= '0;
            end else if (hold) begin
               pend_q <= 1'b1; pend_tx_q <= hold_tx;
            end else begin
               rv_q <= 1'b1; re_q <= 1'b0;
               rd_q <= req_write ? '0 : rd_mux;
            end
         end else if (pend_q && (pend_tx_q ? tx_idle : rx_idle)) begin
            pend_q <= 1'b0;
            rv_q   <= 1'b1; re_q <= 1'b0;
            rd_q   <= pend_tx_q ? tx_word : rx_word;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_reset <= 1'b0; rx_desc_stb <= 1'b0; tx_desc_stb <= 1'b0;
         rx_desc <= '0; tx_desc <= '0;
      end else begin
         dev_reset   <= soft_rst;
         rx_desc_stb <= wr_go && kind == RK_RXDESC;
         tx_desc_stb <= wr_go && kind == RK_TXDESC;
         if (wr_go && kind == RK_RXDESC) rx_desc <= req_wdata;
         if (wr_go && kind == RK_TXDESC) tx_desc <= req_wdata;
      end
   end

   assign resp_valid  = rv_q;
   assign resp_error  = re_q;
   assign resp_rdata  = rd_q;
   assign cfg_word    = cfg_q;
   assign intr_mask   = imask_q;
   assign intr_status = istat_q;
endmodule

// File: rtl/nic_reg_front_chk.sv
module nic_reg_front_chk
   import nic_reg_pkg::*;
#(
   parameter int          AW        = 16,
   parameter int          IW        = 32,
   parameter logic [31:0] IMASK_RST = 32'h0000_0015
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          req_write,
   input logic [AW-1:0] req_addr,
   input logic [3:0]    req_size,
   input logic          resp_valid,
   input logic          resp_error,
   input logic [63:0]   resp_rdata,
   input logic          resp_ready,
   input logic          rx_idle,
   input logic [IW-1:0] intr_post,
   input logic [IW-1:0] intr_status,
   input logic [IW-1:0] intr_mask,
   input logic [31:0]   cfg_word,
   input logic          dev_reset,
   input logic          rx_desc_stb,
   input logic          tx_desc_stb
);
   logic unused_hi;
   assign unused_hi = ^req_addr[AW-1:12];

   a_r2_error_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_error |-> resp_rdata == '0);

   a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !req_ready);

   a_r3_response_held: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_ready |=> resp_valid && $stable(resp_rdata) && $stable(resp_error));

   a_r6_read_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_write && req_addr[11:0] == OFF_ISTAT &&
      req_size == 4'd4 && intr_post == '0 |=> intr_status == '0);

   a_r8_soft_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      dev_reset |-> cfg_word == '0 && intr_mask == IMASK_RST[IW-1:0]);

   a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_desc_stb, tx_desc_stb, dev_reset}));

   a_r10_busy_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_write && req_addr[11:0] == OFF_RXDESC && !rx_idle
      |=> !rx_desc_stb && resp_error);
endmodule

bind nic_reg_front nic_reg_front_chk #(.AW(AW), .IW(IW), .IMASK_RST(IMASK_RST)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
   .resp_valid(resp_valid), .resp_error(resp_error), .resp_rdata(resp_rdata),
   .resp_ready(resp_ready), .rx_idle(rx_idle), .intr_post(intr_post),
   .intr_status(intr_status), .intr_mask(intr_mask), .cfg_word(cfg_word),
   .dev_reset(dev_reset), .rx_desc_stb(rx_desc_stb), .tx_desc_stb(tx_desc_stb)
);

// File: tb/tb_nic_reg_front.sv
`timescale 1ns/1ps
module tb_nic_reg_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b1;
   logic        req_ready, resp_valid, resp_error;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic [63:0] req_wdata = '0, resp_rdata;
   logic [15:0] rx_pkts = 16'd3, tx_pkts = 16'd2;
   logic [19:0] tx_free = 20'd65536, tx_level = 20'd0;
   logic        rx_idle = 1'b1, tx_idle = 1'b1;
   logic [31:0] intr_post = '0, cfg_word, intr_mask, intr_status;
   logic        dev_reset, rx_desc_stb, tx_desc_stb;
   logic [63:0] rx_desc, tx_desc;

   int nchk = 0, nfail = 0;
   logic [31:0] post_with = '0;
   logic s_rx, s_tx, s_rst;
   logic [63:0] s_rxd;

   always #4 clk = ~clk;

   nic_reg_front dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_error(resp_error),
      .resp_rdata(resp_rdata), .resp_ready(resp_ready),
      .rx_pkts(rx_pkts), .tx_pkts(tx_pkts), .tx_free(tx_free), .tx_level(tx_level),
      .rx_idle(rx_idle), .tx_idle(tx_idle), .intr_post(intr_post),
      .cfg_word(cfg_word), .intr_mask(intr_mask), .intr_status(intr_status),
      .dev_reset(dev_reset), .rx_desc_stb(rx_desc_stb), .rx_desc(rx_desc),
      .tx_desc_stb(tx_desc_stb), .tx_desc(tx_desc)
   );

   typedef struct packed {
      logic        wr;
      logic [15:0] addr;
      logic [3:0]  sz;
      logic [63:0] wd;
      logic        err;
      logic [63:0] exp;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 16'h0000, 4'd4, 64'd0,    1'b0, 64'd0},                 // R11 cfg
      '{1'b0, 16'h000C, 4'd4, 64'd0,    1'b0, 64'h15},                // R11 mask
      '{1'b0, 16'h0014, 4'd4, 64'd0,    1'b0, 64'h4000},              // R11 tx maxcopy
      '{1'b0, 16'h0018, 4'd4, 64'd0,    1'b0, 64'hC000},              // R11 rx mark
      '{1'b0, 16'h0058, 4'd8, 64'd0,    1'b0, 64'h0000_0200_1122_3344}, // R11 station
      '{1'b0, 16'h0030, 4'd8, 64'd0,    1'b0, 64'd3},                 // R4
      '{1'b0, 16'h0048, 4'd8, 64'd0,    1'b0, 64'h0000_0004_0000_0002}, // R5 low
      '{1'b0, 16'h0000, 4'd8, 64'd0,    1'b1, 64'd0},                 // R2 size
      '{1'b0, 16'h0004, 4'd4, 64'd0,    1'b1, 64'd0},                 // R2 write-only
      '{1'b1, 16'h0058, 4'd8, 64'd7,    1'b1, 64'd0},                 // R2 read-only
      '{1'b0, 16'h005C, 4'd4, 64'd0,    1'b1, 64'd0},                 // R2 unmapped
      '{1'b1, 16'h0000, 4'd4, 64'hA5,   1'b0, 64'd0},                 // cfg write
      '{1'b0, 16'h0000, 4'd4, 64'd0,    1'b0, 64'hA5},                // cfg readback
      '{1'b1, 16'h000C, 4'd4, 64'h3,    1'b0, 64'd0},                 // mask write
      '{1'b0, 16'h000C, 4'd4, 64'd0,    1'b0, 64'h3},                 // mask readback
      '{1'b0, 16'hA058, 4'd8, 64'd0,    1'b0, 64'h0000_0200_1122_3344}  // R1 alias
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic acc(input logic wr, input logic [15:0] a, input logic [3:0] sz,
                      input logic [63:0] wd, output logic err, output logic [63:0] rd);
      int n;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      intr_post = post_with;
      @(posedge clk);
      #1 req_valid = 1'b0; intr_post = '0;
      @(negedge clk);
      s_rx = rx_desc_stb; s_tx = tx_desc_stb; s_rst = dev_reset; s_rxd = rx_desc;
      n = 0;
      while (!resp_valid && n < 50) begin @(negedge clk); n++; end
      err = resp_error; rd = resp_rdata;
   endtask

   task automatic post(input logic [31:0] v);
      @(negedge clk); intr_post = v;
      @(negedge clk); intr_post = '0;
   endtask

   task automatic run_all();
      logic e;
      logic [63:0] d, held;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset ready", 64'(req_ready), 64'd1);
      chk("R3 reset no response", 64'(resp_valid), 64'd0);
      chk("R11 reset status", 64'(intr_status), 64'd0);
      chk("R11 reset mask", 64'(intr_mask), 64'h15);
      chk("R11 reset cfg", 64'(cfg_word), 64'd0);

      for (int i = 0; i < NV; i++) begin
         acc(VEC[i].wr, VEC[i].addr, VEC[i].sz, VEC[i].wd, e, d);
         chk($sformatf("R2 vector %0d error", i), 64'(e), 64'(VEC[i].err));
         chk($sformatf("R1/R11 vector %0d data", i), d, VEC[i].exp);
      end

      // R4 saturation and busy bit
      rx_pkts = 16'd300; rx_idle = 1'b0;
      acc(1'b0, 16'h0030, 4'd8, 0, e, d);
      chk("R4 saturated busy", d, 64'h0000_0001_0000_00FF);
      // R5 full flag, not low
      tx_pkts = 16'd7; tx_free = 20'd100; tx_level = 20'd20000;
      acc(1'b0, 16'h0048, 4'd8, 0, e, d);
      chk("R5 full", d, 64'h0000_0002_0000_0007);

      // R9 wait read held while rx busy
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0038; req_size = 4'd8;
      @(posedge clk);
      #1 req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 no response while busy", 64'(resp_valid), 64'd0);
      chk("R9 not ready while held", 64'(req_ready), 64'd0);
      rx_idle = 1'b1; rx_pkts = 16'd4;
      @(negedge clk);
      chk("R9 answered after idle", 64'(resp_valid), 64'd1);
      chk("R9 live word", resp_rdata, 64'd4);

      // R6 read clears, same-cycle post survives
      post(32'h9);
      acc(1'b0, 16'h0008, 4'd4, 0, e, d);
      chk("R6 read value", d, 64'h9);
      chk("R6 cleared", 64'(intr_status), 64'd0);
      post(32'h3);
      post_with = 32'h40;
      acc(1'b0, 16'h0008, 4'd4, 0, e, d);
      post_with = '0;
      chk("R6 read old value", d, 64'h3);
      chk("R6 post survives", 64'(intr_status), 64'h40);
      acc(1'b0, 16'h0008, 4'd4, 0, e, d);

      // R7 write clears intersection
      post(32'hF);
      chk("R7 post sets", 64'(intr_status), 64'hF);
      acc(1'b1, 16'h0008, 4'd4, 64'h5, e, d);
      chk("R7 partial clear", 64'(intr_status), 64'hA);
      acc(1'b1, 16'h0008, 4'd4, 64'h30, e, d);
      chk("R7 unset bits no effect", 64'(intr_status), 64'hA);

      // R10 descriptors
      acc(1'b1, 16'h0028, 4'd8, 64'hDEAD_BEEF_0000_1234, e, d);
      chk("R10 rx strobe", 64'(s_rx), 64'd1);
      chk("R10 rx value", s_rxd, 64'hDEAD_BEEF_0000_1234);
      chk("R10 rx ok", 64'(e), 64'd0);
      tx_idle = 1'b0;
      acc(1'b1, 16'h0040, 4'd8, 64'h1, e, d);
      chk("R10 busy error", 64'(e), 64'd1);
      chk("R10 busy no strobe", 64'(s_tx), 64'd0);
      tx_idle = 1'b1;

      // R8 command
      acc(1'b1, 16'h0004, 4'd4, 64'h0, e, d);
      chk("R8 bit clear no reset", 64'(s_rst), 64'd0);
      chk("R8 mask kept", 64'(intr_mask), 64'h3);
      acc(1'b1, 16'h0004, 4'd4, 64'h1, e, d);
      chk("R8 reset pulse", 64'(s_rst), 64'd1);
      chk("R8 cfg cleared", 64'(cfg_word), 64'd0);
      chk("R8 mask default", 64'(intr_mask), 64'h15);
      chk("R8 status cleared", 64'(intr_status), 64'd0);
      @(negedge clk);
      chk("R8 pulse one cycle", 64'(dev_reset), 64'd0);

      // R3 response held under back-pressure
      resp_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0024; req_size = 4'd4;
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      chk("R3 response next cycle", 64'(resp_valid), 64'd1);
      held = resp_rdata;
      chk("R3 data", held, 64'h10000);
      repeat (2) @(negedge clk);
      chk("R3 still valid", 64'(resp_valid), 64'd1);
      chk("R3 data stable", resp_rdata, held);
      chk("R3 blocks new request", 64'(req_ready), 64'd0);
      resp_ready = 1'b1;
      @(negedge clk);
      chk("R3 released", 64'(resp_valid), 64'd0);
      chk("R3 ready again", 64'(req_ready), 64'd1);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end
endmodule